// File: doc/BRIEF.md
# Keypad Code Door Lock

This block watches the key lines of a twelve-key telephone-style keypad (ten digits plus a star key and a hash key) and drives a single bolt control output. The raw key lines are active low and asynchronous to the system clock. They pass through a synchronizer. A priority encoder then reduces them to a 4-bit key code and a "some key is down" flag. An edge detector turns each new press into a one-cycle strobe.

A Gray-coded state machine consumes those strobes and looks for the opening combination: digit 5, then hash, then digit 2. When the combination completes, the bolt output goes high and stays high until the next key press. Any key that breaks the combination returns the machine to the start. A stray 5 is counted as a fresh first key of the combination.

Top module: `keypad_lock`

## Requirements
- R1: While the reset input is low, and after it is released, `door_open` is 0. An asynchronous reset applied part-way through the combination, or while the door is open, discards all progress.
- R2: Key line i (bit i of `key_n`, active low) carries key code i. Lines 0..9 are the digits 0..9, line 10 is star (code 10), and line 11 is hash (code 11). When several lines are low together, the lowest-numbered line is the key that counts.
- R3: The sequence 5, then hash, then 2, each a separate press, sets `door_open` to 1.
- R4: A key that is neither the expected next key nor 5 returns the machine to the start. The door stays closed and the combination must be entered again from the beginning.
- R5: A 5 pressed at any point leaves the machine in the "first key seen" state. A following hash and 2 then open the door.
- R6: A key held down for many cycles counts as one press. Releasing a key has no effect.
- R7: Once open, `door_open` stays 1 with no key activity. The next press closes it. If that press is a 5, it also begins a new combination.
- R8: A key line that falls just before a rising clock edge changes `door_open` after the third rising edge. Two edges are spent in the synchronizer and one in the state register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| key_n | input | 12 | Active-low key lines, one per key |
| door_open | output | 1 | 1 opens the bolt, 0 keeps it closed |

## Verification
The bench aims at the paths where a careless lock would open on a wrong sequence or fail to open on a right one. It feeds a repeated 5 and a 5 in the middle of a combination; a design that drops a stray 5 back to the start would never open on these. It holds the hash key for many cycles; a level-sensitive design would count it twice and reset. It presses several keys together; with the wrong priority, the lock would read a 2 as a hash. It also measures the exact cycle at which the bolt moves, and resets the design part-way through the combination, where an incomplete reset would let a lone 2 open the door.

// File: rtl/keypad_lock_pkg.sv
package keypad_lock_pkg;

  localparam int NUM_KEYS   = 12;
  localparam int KEY_CODE_W = $clog2(NUM_KEYS);

  // Combination, as key codes (code equals key line index)
  localparam logic [KEY_CODE_W-1:0] COMBO_K0 = KEY_CODE_W'(5);
  localparam logic [KEY_CODE_W-1:0] COMBO_K1 = KEY_CODE_W'(11);
  localparam logic [KEY_CODE_W-1:0] COMBO_K2 = KEY_CODE_W'(2);

  // Gray sequence: each forward step flips one bit
  typedef enum logic [1:0] {
    S_IDLE  = 2'b00,
    S_GOT5  = 2'b01,
    S_GOT5H = 2'b11,
    S_OPEN  = 2'b10
  } lock_state_t;

endpackage

// File: rtl/kl_reset_sync.sv
module kl_reset_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);

  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= {chain_q[STAGES-2:0], 1'b1};
  end

  assign rst_n_sync = chain_q[STAGES-1];

endmodule

// File: rtl/kl_line_sync.sv
module kl_line_sync #(
  parameter int WIDTH  = 12,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] lines_async,
  output logic [WIDTH-1:0] lines_sync
);

  logic [WIDTH-1:0] stage_q [STAGES];

  genvar s;
  generate
    for (s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) stage_q[0] <= '1;  // idle: all keys released
          else        stage_q[0] <= lines_async;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) stage_q[s] <= '1;
          else        stage_q[s] <= stage_q[s-1];
        end
      end
    end
  endgenerate

  assign lines_sync = stage_q[STAGES-1];

endmodule

// File: rtl/kl_key_encoder.sv
module kl_key_encoder #(
  parameter int NUM_KEYS = 12,
  parameter int CODE_W   = $clog2(NUM_KEYS)
) (
  input  logic [NUM_KEYS-1:0] key_lines_n,
  output logic [CODE_W-1:0]   key_code,
  output logic                key_valid
);

  // Scan from the top down so the lowest active line is the last assignment
  always_comb begin
    key_valid = 1'b0;
    key_code  = '0;
    for (int i = NUM_KEYS - 1; i >= 0; i--) begin
      if (!key_lines_n[i]) begin
        key_valid = 1'b1;
        key_code  = CODE_W'(i);
      end
    end
  end

endmodule

// File: rtl/kl_press_detect.sv
module kl_press_detect (
  input  logic clk,
  input  logic rst_n,
  input  logic valid_in,
  output logic press
);

  logic valid_prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) valid_prev_q <= 1'b0;
    else        valid_prev_q <= valid_in;
  end

  assign press = valid_in & ~valid_prev_q;

endmodule

// File: rtl/kl_lock_fsm.sv
module kl_lock_fsm
  import keypad_lock_pkg::*;
(
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  press,
  input  logic [KEY_CODE_W-1:0] key_code,
  output lock_state_t           state,
  output logic                  unlocked
);

  lock_state_t state_q, state_d;

  // Next state, evaluated for the key carried with the current strobe
  always_comb begin
    state_d = (key_code == COMBO_K0) ? S_GOT5 : S_IDLE;
    unique case (state_q)
      S_GOT5:  if (key_code == COMBO_K1) state_d = S_GOT5H;
      S_GOT5H: if (key_code == COMBO_K2) state_d = S_OPEN;
      default: ;
    endcase
  end

  // State register, enabled only by a press strobe
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     state_q <= S_IDLE;
    else if (press) state_q <= state_d;
  end

  assign state    = state_q;
  assign unlocked = (state_q == S_OPEN);

endmodule

// File: rtl/keypad_lock.sv
module keypad_lock
  import keypad_lock_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [NUM_KEYS-1:0] key_n,
  output logic                door_open
);

  logic                  rst_n_sync;
  logic [NUM_KEYS-1:0]   key_n_sync;
  logic [KEY_CODE_W-1:0] key_code;
  logic                  key_valid;
  logic                  key_press;
  lock_state_t           lock_state;

  kl_reset_sync #(.STAGES(SYNC_STAGES)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_sync)
  );

  kl_line_sync #(.WIDTH(NUM_KEYS), .STAGES(SYNC_STAGES)) u_sync (
    .clk         (clk),
    .rst_n       (rst_n_sync),
    .lines_async (key_n),
    .lines_sync  (key_n_sync)
  );

  kl_key_encoder #(.NUM_KEYS(NUM_KEYS), .CODE_W(KEY_CODE_W)) u_enc (
    .key_lines_n (key_n_sync),
    .key_code    (key_code),
    .key_valid   (key_valid)
  );

  kl_press_detect u_edge (
    .clk      (clk),
    .rst_n    (rst_n_sync),
    .valid_in (key_valid),
    .press    (key_press)
  );

  kl_lock_fsm u_fsm (
    .clk      (clk),
    .rst_n    (rst_n_sync),
    .press    (key_press),
    .key_code (key_code),
    .state    (lock_state),
    .unlocked (door_open)
  );

endmodule

// File: rtl/keypad_lock_checker.sv
module keypad_lock_checker
  import keypad_lock_pkg::*;
(
  input  logic                  clk,
  input  logic                  rst_n_s,
  input  logic                  press,
  input  logic [KEY_CODE_W-1:0] code,
  input  lock_state_t           state,
  input  logic                  door_open
);

  // R1: reset holds the bolt closed
  assert_reset_closed_R1: assert property (@(posedge clk)
    !rst_n_s |-> !door_open);

  // R6: a strobe lasts one cycle, and the state only moves on a strobe
  assert_single_strobe_R6: assert property (@(posedge clk) disable iff (!rst_n_s)
    press |=> !press);
  assert_hold_without_press_R6: assert property (@(posedge clk) disable iff (!rst_n_s)
    !press |=> $stable(state));

  // R3: completing the combination opens the bolt
  assert_combo_opens_R3: assert property (@(posedge clk) disable iff (!rst_n_s)
    (press && state == S_GOT5H && code == COMBO_K2) |=> door_open);
  assert_open_only_after_combo_R3: assert property (@(posedge clk) disable iff (!rst_n_s)
    $rose(door_open) |-> ($past(state) == S_GOT5H && $past(code) == COMBO_K2));

  // R5: a 5 always lands in the first-key state
  assert_five_restarts_R5: assert property (@(posedge clk) disable iff (!rst_n_s)
    (press && code == COMBO_K0) |=> state == S_GOT5);

  // R4: any other unexpected key goes back to the start
  assert_wrong_key_R4: assert property (@(posedge clk) disable iff (!rst_n_s)
    (press && code != COMBO_K0
      && !(state == S_GOT5  && code == COMBO_K1)
      && !(state == S_GOT5H && code == COMBO_K2)) |=> state == S_IDLE);

  // R7: the bolt never stays open across a press
  assert_press_closes_R7: assert property (@(posedge clk) disable iff (!rst_n_s)
    (press && door_open) |=> !door_open);

endmodule

bind keypad_lock keypad_lock_checker chk_i (
  .clk       (clk),
  .rst_n_s   (rst_n_sync),
  .press     (key_press),
  .code      (key_code),
  .state     (lock_state),
  .door_open (door_open)
);

// File: tb/keypad_lock_tb_top.sv
module keypad_lock_tb_top;

  localparam int KEY_STAR = 10;
  localparam int KEY_HASH = 11;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [11:0] key_n;
  logic        door_open;

  int n_checks = 0;
  int n_fail   = 0;

  typedef struct {
    logic  exp;
    string tag;
  } sb_item_t;

  sb_item_t sb_q[$];
  event     sample_ev;

  always #10 clk = ~clk;  // 50 MHz

  keypad_lock dut_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .key_n     (key_n),
    .door_open (door_open)
  );

  task automatic check(input logic got, input logic exp, input string tag);
    n_checks++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: door_open=%0b expected %0b", tag, got, exp);
    end
  endtask

  // Monitor: pops the scoreboard each time the driver marks a sample point
  initial begin
    forever begin
      @(sample_ev);
      if (sb_q.size() > 0) begin
        sb_item_t it;
        it = sb_q.pop_front();
        check(door_open, it.exp, it.tag);
      end
    end
  end

  // Driver: press a set of lines, release, then queue the expected bolt state
  task automatic press_mask(input logic [11:0] mask, input int hold,
                            input logic exp, input string tag);
    key_n = ~mask;
    repeat (hold) @(negedge clk);
    key_n = '1;
    repeat (4) @(negedge clk);
    sb_q.push_back('{exp: exp, tag: tag});
    -> sample_ev;
    #1;
  endtask

  task automatic press_key(input int k, input logic exp, input string tag);
    press_mask(12'(1) << k, 2, exp, tag);
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  initial begin
    rst_n = 1'b0;
    key_n = '1;
    repeat (2) @(negedge clk);
    check(door_open, 1'b0, "R1 during reset");
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check(door_open, 1'b0, "R1 after reset");

    // R3 basic combination
    press_key(5, 1'b0, "R3 after 5");
    press_key(KEY_HASH, 1'b0, "R3 after 5#");
    press_key(2, 1'b1, "R3 after 5#2");

    // R7 stays open, next key closes
    repeat (20) @(negedge clk);
    check(door_open, 1'b1, "R7 open holds while idle");
    press_key(1, 1'b0, "R7 press closes");
    press_key(KEY_HASH, 1'b0, "R4 # alone");
    press_key(2, 1'b0, "R4 #2 without 5");

    // R4 wrong keys at each step
    press_key(5, 1'b0, "R4 5");
    press_key(KEY_STAR, 1'b0, "R4 5*");
    press_key(2, 1'b0, "R4 5*2 stays closed");
    press_key(5, 1'b0, "R4 5");
    press_key(KEY_HASH, 1'b0, "R4 5#");
    press_key(3, 1'b0, "R4 5#3");
    press_key(2, 1'b0, "R4 5#3 then 2 stays closed");

    // R5 repeated 5 and a 5 inside the combination
    press_key(5, 1'b0, "R5 5");
    press_key(5, 1'b0, "R5 55");
    press_key(KEY_HASH, 1'b0, "R5 55#");
    press_key(2, 1'b1, "R5 55#2 opens");
    press_key(5, 1'b0, "R7 5 from open closes");
    press_key(KEY_HASH, 1'b0, "R7 # after reopen 5");
    press_key(2, 1'b1, "R7 5 from open starts new combination");
    press_key(0, 1'b0, "R7 close");
    press_key(5, 1'b0, "R5 5");
    press_key(KEY_HASH, 1'b0, "R5 5#");
    press_key(5, 1'b0, "R5 5#5");
    press_key(KEY_HASH, 1'b0, "R5 5#5#");
    press_key(2, 1'b1, "R5 5#5#2 opens");
    press_key(9, 1'b0, "R7 close");

    // R6 long hold counts once
    press_key(5, 1'b0, "R6 5");
    press_mask(12'(1) << KEY_HASH, 40, 1'b0, "R6 long #");
    press_key(2, 1'b1, "R6 long # counted once");
    press_mask(12'(1) << 7, 30, 1'b0, "R6 long 7 closes once");

    // R2 priority: lowest line wins
    press_mask((12'(1) << 5) | (12'(1) << 7), 2, 1'b0, "R2 5+7");
    press_mask((12'(1) << KEY_HASH) | (12'(1) << 8), 2, 1'b0, "R2 #+8 reads 8");
    press_key(KEY_HASH, 1'b0, "R2 # after 8");
    press_key(2, 1'b0, "R2 8 broke combination");
    press_key(5, 1'b0, "R2 5");
    press_key(KEY_HASH, 1'b0, "R2 5#");
    press_mask((12'(1) << 2) | (12'(1) << KEY_HASH), 2, 1'b1, "R2 2+# reads 2");
    press_key(4, 1'b0, "R2 close");

    // R8 latency
    press_key(5, 1'b0, "R8 5");
    press_key(KEY_HASH, 1'b0, "R8 5#");
    key_n = ~(12'(1) << 2);
    @(negedge clk);
    check(door_open, 1'b0, "R8 one edge after key");
    @(negedge clk);
    check(door_open, 1'b0, "R8 two edges after key");
    @(negedge clk);
    check(door_open, 1'b1, "R8 three edges after key");
    key_n = '1;
    repeat (4) @(negedge clk);
    press_key(6, 1'b0, "R8 close");

    // R1 reset in mid-combination and while open
    press_key(5, 1'b0, "R1 5");
    press_key(KEY_HASH, 1'b0, "R1 5#");
    do_reset();
    check(door_open, 1'b0, "R1 reset mid-combination");
    press_key(2, 1'b0, "R1 lone 2 after reset");
    press_key(5, 1'b0, "R1 5");
    press_key(KEY_HASH, 1'b0, "R1 5#");
    press_key(2, 1'b1, "R1 reopen");
    do_reset();
    check(door_open, 1'b0, "R1 reset while open");

    repeat (4) @(negedge clk);
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog: run did not finish, got timeout expected completion");
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

endmodule